// File: doc/BRIEF.md
# Double-Data-Rate Two-Beat Burst Memory

This block is an on-chip memory with an independent read port and write port. The two ports share one address bus. Each access moves a burst of two words, one word on each clock phase. Storage is split into two banks of half depth. Word 0 of a burst sits in bank 0 and word 1 in bank 1, so one address names a whole burst. A write can mask any of its 9-bit lanes.

The model uses a single core clock `clk` that runs at twice the K rate, so every rising edge of `clk` stands for one edge of the K pair. Input `k_ph` marks each edge: 1 means a K rise and 0 means a K# rise. In the same way, `c_ph` marks the edges of the output clock pair: 1 means a C rise. When `one_clk` is 1, read data follows the K pair instead of the C pair. The read command and the read address are taken on a K rise. A write command is also taken on a K rise, together with write word 0 and its lane selects. The write address is taken on the following K# rise, together with word 1. Output `q_oe` stands for the tri-state output enable. While it is low, `q` is driven to zero.

Top module: `ddrb_sram`

## Requirements
- R1: When `wps_n` is 1 at a K rise, no write takes place, and the data, lane selects and address of that K cycle leave the memory unchanged. When `wps_n` is 0, a write starts.
- R2: When `rps_n` is 0 at a K rise, a read starts. It produces exactly two output beats: bank 0 word first, then bank 1 word, with `q_oe` high for both.
- R3: The read address is taken from `addr` on the K rise, and the write address on the K# rise that follows the write command. An address presented while its port is not selected has no effect.
- R4: Write data on `d` is taken on the K rise, which gives word 0, and on the next K# rise, which gives word 1. A later read of that address returns word 0 first and then word 1.
- R5: `bw_n[i]` (active low) qualifies bits 9*i+8..9*i of the word taken on the same edge. A lane whose select is 1 keeps its previous contents.
- R6: When `one_clk` is 1, or when the C pair is in phase with K, word 0 appears on `q` after the second edge following the read-command edge (one full K cycle later), and word 1 appears after the next edge.
- R7: When `one_clk` is 0 and the C pair lags K by half a cycle (`c_ph` = not `k_ph`), each output beat comes one edge later than in R6.
- R8: Once reads stop, a burst already issued still completes. `q_oe` then falls on the next output-pair rising edge that has no burst to launch. While `q_oe` is 0, `q` is 0.
- R9: A read and a write to the same address in the same K cycle return the data stored before that write.
- R10: Reset (synchronous, active-low `rst_n`) forces `q_oe` to 0 and `q` to 0, and drops a write whose K# commit edge falls inside reset.
- R11: Reads in consecutive K cycles give back-to-back bursts with `q_oe` held high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate core clock; each rising edge is one K-pair edge |
| rst_n | input | 1 | Synchronous active-low reset |
| k_ph | input | 1 | 1 marks a K rise, 0 marks a K# rise |
| c_ph | input | 1 | 1 marks a C rise, 0 marks a C# rise |
| one_clk | input | 1 | 1 sends read data on the K pair instead of the C pair |
| rps_n | input | 1 | Read port select, active low, sampled on a K rise |
| wps_n | input | 1 | Write port select, active low, sampled on a K rise |
| addr | input | AW | Shared address: read on a K rise, write on a K# rise |
| d | input | WIDTH | Write data, one word per edge |
| bw_n | input | WIDTH/9 | Active-low lane write selects, one per 9-bit lane |
| q | output | WIDTH | Read data, zero while the output is disabled |
| q_oe | output | 1 | Output enable standing for the tri-state driver |

## Verification
A read issued on K-rise edge N gives its first word after edge N+2 and its second word after edge N+3. With a lagging C pair, the two words come after edges N+3 and N+4. A write becomes visible to any read taken on a K rise after its K# commit edge. The bench logs `q` and `q_oe` half a period after every edge. It files each predicted beat under the absolute edge index where the beat is due. It then compares the whole timeline, so that every edge without a predicted beat must show the output disabled. The checker restates the same latencies as fixed-depth properties for each output mode.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;
  localparam int LANE_BITS = 9;
  localparam int MAX_LANES = 4;
  localparam int MAX_BITS  = LANE_BITS * MAX_LANES;

  // Replace every lane whose keep bit is 0 with the new word's lane.
  function automatic logic [MAX_BITS-1:0] lane_merge(
    input logic [MAX_BITS-1:0]  old_w,
    input logic [MAX_BITS-1:0]  new_w,
    input logic [MAX_LANES-1:0] keep
  );
    logic [MAX_BITS-1:0] r;
    r = old_w;
    for (int i = 0; i < MAX_LANES; i++) begin
      if (!keep[i]) r[i*LANE_BITS +: LANE_BITS] = new_w[i*LANE_BITS +: LANE_BITS];
    end
    return r;
  endfunction
endpackage

// File: rtl/ddrb_wr_capture.sv
module ddrb_wr_capture #(
  parameter int WIDTH = 36,
  parameter int AW    = 8,
  localparam int LANES = WIDTH / ddrb_pkg::LANE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             k_ph,
  input  logic             wps_n,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] d,
  input  logic [LANES-1:0] bw_n,
  output logic             commit,
  output logic [AW-1:0]    commit_addr,
  output logic [WIDTH-1:0] w0,
  output logic [LANES-1:0] keep0,
  output logic [WIDTH-1:0] w1,
  output logic [LANES-1:0] keep1
);
  logic pend;

  // The K rise takes the command, word 0 and its lane selects.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (k_ph) begin
      pend <= !wps_n;
    end else begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (k_ph && !wps_n) begin
      w0    <= d;
      keep0 <= bw_n;
    end
  end

  // The K# rise brings the address and word 1; both banks commit on that edge.
  assign commit      = pend & ~k_ph & rst_n;
  assign commit_addr = addr;
  assign w1          = d;
  assign keep1       = bw_n;
endmodule

// File: rtl/ddrb_bank.sv
module ddrb_bank #(
  parameter int WIDTH = 36,
  parameter int AW    = 8,
  localparam int LANES = WIDTH / ddrb_pkg::LANE_BITS,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [LANES-1:0] keep,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  import ddrb_pkg::*;

  logic [WIDTH-1:0]    mem [DEPTH];
  logic [MAX_BITS-1:0] merged_full;
  logic [WIDTH-1:0]    merged;

  always_comb begin
    merged_full = lane_merge(MAX_BITS'(mem[waddr]), MAX_BITS'(wdata), MAX_LANES'(keep));
    merged      = merged_full[WIDTH-1:0];
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= merged;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ddrb_rd_out.sv
module ddrb_rd_out #(
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             k_ph,
  input  logic             out_pos,
  input  logic             fetch_go,
  input  logic [WIDTH-1:0] f0,
  input  logic [WIDTH-1:0] f1,
  output logic [WIDTH-1:0] q,
  output logic             q_oe,
  output logic             launch
);
  logic             fetch_v, stage_v, beat1;
  logic [WIDTH-1:0] s0, s1, w1;

  assign launch = out_pos & stage_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_v <= 1'b0;
      stage_v <= 1'b0;
      beat1   <= 1'b0;
      q       <= '0;
      q_oe    <= 1'b0;
    end else begin
      if (k_ph) fetch_v <= fetch_go;
      else      stage_v <= fetch_v;
      if (out_pos) begin
        if (stage_v) begin
          q     <= s0;
          w1    <= s1;
          q_oe  <= 1'b1;
          beat1 <= 1'b1;
        end else begin
          q     <= '0;
          q_oe  <= 1'b0;
          beat1 <= 1'b0;
        end
      end else if (beat1) begin
        q     <= w1;
        beat1 <= 1'b0;
      end
    end
  end

  // Staging on K# holds a burst until the selected output pair launches it.
  always_ff @(posedge clk) begin
    if (!k_ph) begin
      s0 <= f0;
      s1 <= f1;
    end
  end
endmodule

// File: rtl/ddrb_sram.sv
module ddrb_sram #(
  parameter int WIDTH = 36,
  parameter int AW    = 8,
  localparam int LANES = WIDTH / ddrb_pkg::LANE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             k_ph,
  input  logic             c_ph,
  input  logic             one_clk,
  input  logic             rps_n,
  input  logic             wps_n,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] d,
  input  logic [LANES-1:0] bw_n,
  output logic [WIDTH-1:0] q,
  output logic             q_oe
);
  logic             wr_commit, out_pos, launch, fetch_go;
  logic [AW-1:0]    wr_addr;
  logic [WIDTH-1:0] wdat [2];
  logic [LANES-1:0] wkeep [2];
  logic [WIDTH-1:0] rdat [2];

  assign fetch_go = k_ph & ~rps_n;
  assign out_pos  = one_clk ? k_ph : c_ph;

  ddrb_wr_capture #(.WIDTH(WIDTH), .AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .k_ph(k_ph), .wps_n(wps_n), .addr(addr),
    .d(d), .bw_n(bw_n), .commit(wr_commit), .commit_addr(wr_addr),
    .w0(wdat[0]), .keep0(wkeep[0]), .w1(wdat[1]), .keep1(wkeep[1])
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ddrb_bank #(.WIDTH(WIDTH), .AW(AW)) u_bank (
      .clk(clk), .we(wr_commit), .waddr(wr_addr), .wdata(wdat[b]),
      .keep(wkeep[b]), .re(fetch_go), .raddr(addr), .rdata(rdat[b])
    );
  end

  ddrb_rd_out #(.WIDTH(WIDTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .k_ph(k_ph), .out_pos(out_pos),
    .fetch_go(fetch_go), .f0(rdat[0]), .f1(rdat[1]),
    .q(q), .q_oe(q_oe), .launch(launch)
  );
endmodule

// File: rtl/ddrb_sram_chk.sv
module ddrb_sram_chk #(
  parameter int WIDTH = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             k_ph,
  input logic             c_ph,
  input logic             one_clk,
  input logic             rps_n,
  input logic             wps_n,
  input logic [WIDTH-1:0] q,
  input logic             q_oe,
  input logic             wr_commit,
  input logic             out_pos,
  input logic             launch
);
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !q_oe |-> q == '0);

  p_commit_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(k_ph && !wps_n));

  p_lat_inphase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (k_ph && !rps_n && (one_clk || c_ph)) |-> ##3 q_oe);

  p_lat_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (k_ph && !rps_n && !one_clk && !c_ph) |-> ##4 q_oe);

  p_two_beats_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_oe) |=> q_oe);

  p_fall_on_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_oe) |-> $past(out_pos));

  p_launch_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> q_oe);
endmodule

bind ddrb_sram ddrb_sram_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .k_ph(k_ph), .c_ph(c_ph), .one_clk(one_clk),
  .rps_n(rps_n), .wps_n(wps_n), .q(q), .q_oe(q_oe),
  .wr_commit(wr_commit), .out_pos(out_pos), .launch(launch)
);

// File: tb/ddrb_sram_test.sv
module ddrb_sram_test;
  localparam int CLK_P = 10;
  localparam int W     = 36;
  localparam int A     = 8;
  localparam int NLOG  = 2048;

  typedef struct packed {
    logic         rd;
    logic [A-1:0] ra;
    logic         wr;
    logic [A-1:0] wa;
    logic [W-1:0] d0;
    logic [3:0]   b0;
    logic [W-1:0] d1;
    logic [3:0]   b1;
    logic [7:0]   req;
  } vec_t;

  // Stimulus table; the expected beats come from the reference model below.
  localparam vec_t VEC [12] = '{
    '{1'b0, 8'h00, 1'b1, 8'h10, 36'h123456789, 4'h0, 36'hABCDEF012, 4'h0, 8'd4},  // R4
    '{1'b0, 8'h00, 1'b1, 8'h20, 36'h0F0F0F0F0, 4'h0, 36'h111111111, 4'h0, 8'd4},  // R4
    '{1'b1, 8'h10, 1'b1, 8'h30, 36'h200000001, 4'h0, 36'h300000003, 4'h0, 8'd2},  // R2
    '{1'b1, 8'h20, 1'b1, 8'h10, 36'hFFFFFFFFF, 4'h5, 36'h000000000, 4'hA, 8'd3},  // R3
    '{1'b1, 8'h10, 1'b0, 8'h10, 36'h555555555, 4'h0, 36'h555555555, 4'h0, 8'd5},  // R5 mask result, R1 ignored write
    '{1'b1, 8'h30, 1'b1, 8'h30, 36'h777777777, 4'h0, 36'h888888888, 4'h0, 8'd9},  // R9
    '{1'b1, 8'h30, 1'b0, 8'h00, 36'h0,         4'h0, 36'h0,         4'h0, 8'd9},  // R9 new data
    '{1'b0, 8'h33, 1'b1, 8'h20, 36'hDEADBEEF0, 4'hF, 36'hCAFEF00D1, 4'hF, 8'd5},  // R5 all lanes kept
    '{1'b1, 8'h20, 1'b0, 8'h00, 36'h0,         4'h0, 36'h0,         4'h0, 8'd5},  // R5
    '{1'b0, 8'h00, 1'b0, 8'h00, 36'h0,         4'h0, 36'h0,         4'h0, 8'd8},  // R8 gap
    '{1'b1, 8'h10, 1'b1, 8'hFF, 36'h9ABCDEF01, 4'h0, 36'h13579BDF0, 4'h0, 8'd3},  // R3 top address
    '{1'b1, 8'hFF, 1'b0, 8'h00, 36'h0,         4'h0, 36'h0,         4'h0, 8'd3}   // R3
  };

  logic         clk = 1'b0;
  logic         rst_n, k_ph, c_ph, one_clk, rps_n, wps_n;
  logic [A-1:0] addr;
  logic [W-1:0] d;
  logic [3:0]   bw_n;
  logic [W-1:0] q;
  logic         q_oe;

  ddrb_sram #(.WIDTH(W), .AW(A)) uut (
    .clk(clk), .rst_n(rst_n), .k_ph(k_ph), .c_ph(c_ph), .one_clk(one_clk),
    .rps_n(rps_n), .wps_n(wps_n), .addr(addr), .d(d), .bw_n(bw_n),
    .q(q), .q_oe(q_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  int edge_n = 0;
  int n_chk  = 0;
  int n_fail = 0;
  int cmp_start = 0;
  logic         lag = 1'b0;
  logic [W-1:0] ref0 [256];
  logic [W-1:0] ref1 [256];
  logic [W-1:0] cap_q [NLOG];
  logic         cap_oe [NLOG];
  logic [W-1:0] exp_q [NLOG];
  logic         exp_v [NLOG];
  int           exp_req [NLOG];

  always @(posedge clk) edge_n <= edge_n + 1;
  always @(negedge clk) begin
    cap_q[edge_n % NLOG]  = q;
    cap_oe[edge_n % NLOG] = q_oe;
  end

  task automatic check(input bit ok, input int req, input logic [W-1:0] act, input logic [W-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d actual %h expected %h (t=%0t)", req, act, expv, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Independent lane merge: a lane is replaced when its active-low select is 0.
  function automatic logic [W-1:0] mix(input logic [W-1:0] old_w, input logic [W-1:0] new_w, input logic [3:0] sel_n);
    logic [W-1:0] m;
    m = '0;
    for (int l = 0; l < 4; l++) if (!sel_n[l]) m |= (36'h1FF << (9 * l));
    return (old_w & ~m) | (new_w & m);
  endfunction

  // One K cycle: the K-rise half, then the K#-rise half.
  task automatic kcycle(input vec_t v);
    int cmd, dl;
    @(negedge clk);
    k_ph  = 1'b1;
    c_ph  = lag ? 1'b0 : 1'b1;
    rps_n = !v.rd;
    wps_n = !v.wr;
    addr  = v.rd ? v.ra : 8'hA5;   // R3: an unselected read address is ignored
    d     = v.d0;
    bw_n  = v.b0;
    cmd   = edge_n + 1;
    if (v.rd) begin
      dl = (one_clk || !lag) ? 2 : 3;
      exp_v[(cmd+dl) % NLOG]     = 1'b1;
      exp_q[(cmd+dl) % NLOG]     = ref0[v.ra];
      exp_req[(cmd+dl) % NLOG]   = int'(v.req);
      exp_v[(cmd+dl+1) % NLOG]   = 1'b1;
      exp_q[(cmd+dl+1) % NLOG]   = ref1[v.ra];
      exp_req[(cmd+dl+1) % NLOG] = int'(v.req);
    end
    @(negedge clk);
    k_ph  = 1'b0;
    c_ph  = lag ? 1'b1 : 1'b0;
    rps_n = 1'b1;
    wps_n = 1'b1;
    addr  = v.wr ? v.wa : 8'h5A;
    d     = v.d1;
    bw_n  = v.b1;
    if (v.wr) begin
      ref0[v.wa] = mix(ref0[v.wa], v.d0, v.b0);
      ref1[v.wa] = mix(ref1[v.wa], v.d1, v.b1);
    end
  endtask

  function automatic vec_t idle_v();
    return '{1'b0, 8'h00, 1'b0, 8'h00, 36'h0, 4'h0, 36'h0, 4'h0, 8'd8};
  endfunction

  function automatic vec_t rd_v(input logic [A-1:0] a, input int req);
    return '{1'b1, a, 1'b0, 8'h00, 36'h0, 4'h0, 36'h0, 4'h0, 8'(req)};
  endfunction

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int i = 0; i < NLOG; i++) exp_v[i] = 1'b0;
    rst_n = 1'b0; k_ph = 1'b1; c_ph = 1'b1; one_clk = 1'b1;
    rps_n = 1'b1; wps_n = 1'b1; addr = '0; d = '0; bw_n = '1;
    for (int i = 0; i < 3; i++) kcycle(idle_v());
    // R10: outputs quiet under reset
    check(q_oe == 1'b0, 10, W'(q_oe), W'(0));
    check(q == '0, 10, q, '0);
    @(negedge clk);
    rst_n = 1'b1;
    k_ph  = 1'b0;
    c_ph  = 1'b0;
    cmp_start = edge_n + 1;

    // Table walk in single-clock mode (R1..R6, R9)
    for (int i = 0; i < 12; i++) kcycle(VEC[i]);
    for (int i = 0; i < 3; i++) kcycle(idle_v());

    // R7 and R11: lagging C pair, back-to-back reads
    one_clk = 1'b0;
    lag     = 1'b1;
    kcycle(idle_v());
    kcycle(rd_v(8'h10, 7));
    kcycle(rd_v(8'h30, 11));
    kcycle(rd_v(8'hFF, 11));
    for (int i = 0; i < 3; i++) kcycle(idle_v());

    // R6: C pair in phase with K
    lag = 1'b0;
    kcycle(idle_v());
    kcycle(rd_v(8'h20, 6));
    for (int i = 0; i < 3; i++) kcycle(idle_v());

    // R10: a write whose K# commit edge falls in reset is dropped
    one_clk = 1'b1;
    @(negedge clk);
    k_ph = 1'b1; c_ph = 1'b1; wps_n = 1'b0; rps_n = 1'b1;
    addr = 8'h00; d = 36'h0DEAD0BAD; bw_n = 4'h0;
    @(negedge clk);
    k_ph = 1'b0; c_ph = 1'b0; wps_n = 1'b1; rst_n = 1'b0;
    addr = 8'h10; d = 36'h0BAD0DEAD; bw_n = 4'h0;
    @(negedge clk);
    check(q_oe == 1'b0, 10, W'(q_oe), W'(0));
    rst_n = 1'b1;
    k_ph = 1'b0; c_ph = 1'b0;
    kcycle(idle_v());
    kcycle(rd_v(8'h10, 10));
    for (int i = 0; i < 4; i++) kcycle(idle_v());

    // Timeline compare: predicted beats, and quiet output on every other edge (R8)
    for (int i = cmp_start; i < edge_n; i++) begin
      if (exp_v[i % NLOG]) begin
        check(cap_oe[i % NLOG] == 1'b1, exp_req[i % NLOG], W'(cap_oe[i % NLOG]), W'(1));
        check(cap_q[i % NLOG] == exp_q[i % NLOG], exp_req[i % NLOG], cap_q[i % NLOG], exp_q[i % NLOG]);
      end else begin
        check(cap_oe[i % NLOG] == 1'b0, 8, W'(cap_oe[i % NLOG]), W'(0));
        check(cap_q[i % NLOG] == '0, 8, cap_q[i % NLOG], '0);
      end
    end
    report();
  end
endmodule